// File: doc/BRIEF.md
# Nonvolatile wiper setting controller

This block keeps the 8-bit setting of a 256-step digital resistor divider together with a small emulated nonvolatile byte store, and moves values between the two. A register array stands in for the nonvolatile cells. It has no reset, so its contents survive a reset. A parameterised down-counter stands in for the programming time of the cells. After every reset the controller copies the stored home byte (location `WIPER_LOC`) into the wiper register. Every command that writes the memory holds a busy flag for a fixed number of cycles, and the serial front end is meant to stop acknowledging its address while that flag is high.

Requests arrive on a valid/ready port. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low during the power-on refresh, during a write cycle, and while an earlier read response is still unconsumed. Each accepted read produces one response on `rsp_valid`/`rsp_data`. That response stays up, with its data unchanged, until `rsp_ready` is seen high at a clock edge, so a downstream that stalls stalls the request port as well. A software lock flag refuses memory writes. The two highest addresses return factory tolerance bytes and refuse writes.

Top module: `nv_wiper_ctrl`

## Requirements
- R1: While `rst_n` is low, `busy`=1, `req_ready`=0, `rsp_valid`=0, `err`=0, `wp_on`=0 and `wiper`=0. After release, `busy` stays high for at most `REFRESH_CYC` cycles. When it drops, `wiper` equals the stored byte at location 0.
- R2: Command 3'b000 with `req_write`=1 loads `req_wdata` into `wiper` in the cycle after acceptance. Codes 0x00, 0x80 and 0xFF are all accepted. With `req_write`=0 the command returns `wiper` as a response.
- R3: Command 3'b001 with `req_write`=1 at an address below 30 starts a write cycle. `busy` is high for exactly `WRITE_CYC` cycles after acceptance, and the new byte is readable once `busy` drops. With `req_write`=0 the command returns the byte at `req_addr`.
- R4: Command 3'b110 (store) copies the `wiper` value current at acceptance into location 0, using the same `WRITE_CYC` write cycle.
- R5: Command 3'b101 (restore) loads location 0 into `wiper` in the cycle after acceptance and never raises `busy`.
- R6: Command 3'b010 with `req_write`=1 sets `wp_on` to bit 0 of `req_wdata`. With `req_write`=0 it returns `{7'b0, wp_on}`. While `wp_on`=1, memory writes are refused, and so are stores when `WP_BLOCKS_STORE`=1 (the default). A refused request pulses `err`, leaves `busy` low and leaves the stored bytes unchanged.
- R7: Reading address 30 returns `TOL_SIGN_INT`: bit 7 is the sign (0 positive, 1 negative) and bits 6:0 are the integer percent. Reading address 31 returns `TOL_FRAC`, the fraction in units of 2^-8 percent. A write to either address is ignored, pulses `err` and leaves `busy` low.
- R8: `req_ready` is 0 whenever `busy` is 1 or a response is pending that `rsp_ready` does not consume. While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid` stays 1 and `rsp_data` holds its value.
- R9: Command codes 3'b011 and 3'b111 pulse `err` and change nothing. Command 3'b100 does nothing and does not pulse `err`.
- R10: `err` is high for one cycle, in the cycle after the offending request was accepted, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts the power-on refresh |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_cmd | input | 3 | Command code |
| req_write | input | 1 | 1 = write direction, 0 = read direction (wiper, memory and lock commands) |
| req_addr | input | 5 | Memory address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_data | output | 8 | Read response byte |
| busy | output | 1 | Refresh or write cycle in progress |
| err | output | 1 | One-cycle pulse for a refused or unknown request |
| wiper | output | 8 | Current wiper setting |
| wp_on | output | 1 | Write-protect flag |

## Verification
Some properties are checked on every cycle. The request port is closed while busy, a stalled response holds steady, a refresh never outlasts its bound, the write counter only counts down, no write ever reaches the tolerance locations, a busy window that opens under the lock must be a permitted store, a restore never raises busy, and every error pulse follows an accepted request. Other behaviour is only visible through the bench scenarios: the exact length of a write cycle, the data a store or restore moves, the survival of stored bytes across a reset, the tolerance values, and the byte-level results of refused writes. A scoreboard compares each read response with the value expected by the requirements.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  localparam int CMD_W = 3;

  localparam logic [CMD_W-1:0] CMD_WIPER   = 3'b000;
  localparam logic [CMD_W-1:0] CMD_MEM     = 3'b001;
  localparam logic [CMD_W-1:0] CMD_LOCK    = 3'b010;
  localparam logic [CMD_W-1:0] CMD_NOP     = 3'b100;
  localparam logic [CMD_W-1:0] CMD_RESTORE = 3'b101;
  localparam logic [CMD_W-1:0] CMD_STORE   = 3'b110;

  typedef enum logic [1:0] {
    ST_REFRESH = 2'd0,
    ST_IDLE    = 2'd1,
    ST_PROG    = 2'd2
  } state_t;

  typedef enum logic [1:0] {
    SEL_WIPER = 2'd0,
    SEL_MEM   = 2'd1,
    SEL_LOCK  = 2'd2
  } rd_sel_t;

  typedef struct packed {
    logic    wiper_wr;
    logic    restore;
    logic    prog;
    logic    prog_from_wiper;
    logic    lock_wr;
    logic    rd;
    rd_sel_t rd_sel;
    logic    err;
  } action_t;
endpackage

// File: rtl/nvw_timer.sv
module nvw_timer #(
  parameter int CNT_W    = 5,
  parameter int RST_LOAD = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= CNT_W'(RST_LOAD);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R3: without a load the counter only steps down by one
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/nvw_store.sv
module nvw_store #(
  parameter int                DATA_W       = 8,
  parameter int                ADDR_W       = 5,
  parameter int                WIPER_LOC    = 0,
  parameter logic [DATA_W-1:0] TOL_SIGN_INT = 8'h1C,
  parameter logic [DATA_W-1:0] TOL_FRAC     = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] home_data
);
  localparam int                DEPTH    = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ROM_HI   = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] ROM_LO   = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] HOME_ADR = ADDR_W'(WIPER_LOC);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  always_comb begin
    if (rd_addr == ROM_HI)      rd_data = TOL_SIGN_INT;
    else if (rd_addr == ROM_LO) rd_data = TOL_FRAC;
    else                        rd_data = cells[rd_addr];
  end

  assign home_data = cells[HOME_ADR];

  // R7: the factory tolerance locations never receive a write
  assert_rom_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < ROM_HI));
endmodule

// File: rtl/nvw_decode.sv
module nvw_decode
  import nvw_pkg::*;
#(
  parameter int ADDR_W          = 5,
  parameter bit WP_BLOCKS_STORE = 1'b1
) (
  input  logic [CMD_W-1:0]  cmd,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp,
  output action_t           act
);
  localparam logic [ADDR_W-1:0] ROM_BASE = ADDR_W'((1 << ADDR_W) - 2);

  always_comb begin
    act = '0;
    case (cmd)
      CMD_WIPER: begin
        if (write) act.wiper_wr = 1'b1;
        else begin act.rd = 1'b1; act.rd_sel = SEL_WIPER; end
      end
      CMD_MEM: begin
        if (write) begin
          if (addr >= ROM_BASE || wp) act.err  = 1'b1;
          else                        act.prog = 1'b1;
        end else begin
          act.rd = 1'b1; act.rd_sel = SEL_MEM;
        end
      end
      CMD_LOCK: begin
        if (write) act.lock_wr = 1'b1;
        else begin act.rd = 1'b1; act.rd_sel = SEL_LOCK; end
      end
      CMD_NOP:     ;
      CMD_RESTORE: act.restore = 1'b1;
      CMD_STORE: begin
        if (wp && WP_BLOCKS_STORE) act.err = 1'b1;
        else begin act.prog = 1'b1; act.prog_from_wiper = 1'b1; end
      end
      default:     act.err = 1'b1;
    endcase
  end
endmodule

// File: rtl/nv_wiper_ctrl.sv
module nv_wiper_ctrl
  import nvw_pkg::*;
#(
  parameter int                DATA_W          = 8,
  parameter int                ADDR_W          = 5,
  parameter int                WRITE_CYC       = 16,
  parameter int                REFRESH_CYC     = 8,
  parameter int                WIPER_LOC       = 0,
  parameter bit                WP_BLOCKS_STORE = 1'b1,
  parameter logic [DATA_W-1:0] TOL_SIGN_INT    = 8'h1C,
  parameter logic [DATA_W-1:0] TOL_FRAC        = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              err,
  output logic [DATA_W-1:0] wiper,
  output logic              wp_on
);
  localparam int MAX_CYC = (WRITE_CYC > REFRESH_CYC) ? WRITE_CYC : REFRESH_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  state_t            state;
  action_t           act;
  logic              take;
  logic              tmr_zero;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic              pend_store;
  logic [DATA_W-1:0] mem_rd;
  logic [DATA_W-1:0] home;
  logic              mem_wr;

  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE) && (!rsp_valid || rsp_ready);
  assign take      = req_valid && req_ready;
  assign mem_wr    = (state == ST_PROG) && tmr_zero;

  nvw_decode #(.ADDR_W(ADDR_W), .WP_BLOCKS_STORE(WP_BLOCKS_STORE)) u_decode (
    .cmd(req_cmd), .write(req_write), .addr(req_addr), .wp(wp_on), .act(act)
  );

  nvw_timer #(.CNT_W(CNT_W), .RST_LOAD(REFRESH_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(take && act.prog),
    .load_val(CNT_W'(WRITE_CYC - 1)), .zero(tmr_zero)
  );

  nvw_store #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIPER_LOC(WIPER_LOC),
    .TOL_SIGN_INT(TOL_SIGN_INT), .TOL_FRAC(TOL_FRAC)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(mem_wr), .wr_addr(pend_addr),
    .wr_data(pend_data), .rd_addr(req_addr), .rd_data(mem_rd), .home_data(home)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_REFRESH;
      wiper      <= '0;
      wp_on      <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      err        <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
      pend_store <= 1'b0;
    end else begin
      err <= take && act.err;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (state)
        ST_REFRESH: if (tmr_zero) begin
          wiper <= home;
          state <= ST_IDLE;
        end
        ST_PROG: if (tmr_zero) state <= ST_IDLE;
        default: if (take) begin
          if (act.wiper_wr) wiper <= req_wdata;
          if (act.restore)  wiper <= home;
          if (act.lock_wr)  wp_on <= req_wdata[0];
          if (act.prog) begin
            state      <= ST_PROG;
            pend_store <= act.prog_from_wiper;
            pend_addr  <= act.prog_from_wiper ? ADDR_W'(WIPER_LOC) : req_addr;
            pend_data  <= act.prog_from_wiper ? wiper : req_wdata;
          end
          if (act.rd) begin
            rsp_valid <= 1'b1;
            case (act.rd_sel)
              SEL_WIPER: rsp_data <= wiper;
              SEL_MEM:   rsp_data <= mem_rd;
              default:   rsp_data <= {{(DATA_W-1){1'b0}}, wp_on};
            endcase
          end
        end
      endcase
    end
  end

  // Cycle count since reset, used only to bound the refresh window
  logic [CNT_W:0] refresh_age;
  always_ff @(posedge clk) begin
    if (!rst_n) refresh_age <= '0;
    else if (state == ST_REFRESH && refresh_age != '1) refresh_age <= refresh_age + 1'b1;
  end

  // R1: refresh finishes within its bound
  assert_refresh_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REFRESH) |-> (refresh_age < (CNT_W+1)'(REFRESH_CYC)));

  // R8: request port closed while busy
  assert_ready_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R8: a stalled response stays valid and unchanged
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R10: every error pulse follows an accepted request
  assert_err_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req_valid && req_ready));

  // R6: a write cycle that opens under the lock must be a permitted store
  assert_wp_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && wp_on) |-> (!WP_BLOCKS_STORE && pend_store));

  // R5: restore loads the home byte without a write cycle
  assert_restore_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && act.restore) |=> (!busy && wiper == $past(home)));
endmodule

// File: tb/tb_nv_wiper_ctrl.sv
module tb_nv_wiper_ctrl;
  localparam int WCYC = 16;
  localparam int RCYC = 8;
  localparam logic [7:0] TOL_HI = 8'h1C;
  localparam logic [7:0] TOL_LO = 8'h0F;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [2:0] req_cmd;
  logic [4:0] req_addr;
  logic [7:0] req_wdata;
  logic rsp_valid, rsp_ready;
  logic [7:0] rsp_data;
  logic busy, err, wp_on;
  logic [7:0] wiper;

  always #10 clk = ~clk;

  nv_wiper_ctrl #(.WRITE_CYC(WCYC), .REFRESH_CYC(RCYC),
                  .TOL_SIGN_INT(TOL_HI), .TOL_FRAC(TOL_LO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .busy(busy), .err(err), .wiper(wiper), .wp_on(wp_on)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_rsp(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // Monitor: pops the scoreboard whenever a response transfers
  always begin
    @(negedge clk);
    #1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected response", rsp_data, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  // Driver: called and returns on a falling edge; returns half a cycle after acceptance
  task automatic send(input logic [2:0] cmd, input logic wr, input logic [4:0] adr,
                      input logic [7:0] dat);
    req_cmd = cmd; req_write = wr; req_addr = adr; req_wdata = dat;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic finish_run();
    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] held;
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy && !req_ready && !rsp_valid && !err && !wp_on && wiper == 8'h00,
        "R1 reset state", {busy, req_ready, rsp_valid, err, wp_on}, 5'b10000);
    rst_n = 1'b1;
    wait_idle(n);
    chk(n > 0 && n <= RCYC, "R1 refresh length", n, RCYC);

    // R2 wiper writes and reads across codes
    send(3'b000, 1'b1, 5'd0, 8'h80);
    chk(wiper == 8'h80, "R2 wiper mid", wiper, 8'h80);
    send(3'b000, 1'b0, 5'd0, 8'h00); expect_rsp(8'h80, "R2 read mid");
    send(3'b000, 1'b1, 5'd0, 8'h00);
    chk(wiper == 8'h00, "R2 wiper zero", wiper, 8'h00);
    send(3'b000, 1'b1, 5'd0, 8'hFF);
    chk(wiper == 8'hFF, "R2 wiper full", wiper, 8'hFF);
    send(3'b000, 1'b0, 5'd0, 8'h00); expect_rsp(8'hFF, "R2 read full");

    // R3 memory write cycle
    send(3'b001, 1'b1, 5'd3, 8'h3C);
    chk(busy && !req_ready, "R8 ready low while busy", req_ready, 0);
    wait_idle(n);
    chk(n == WCYC, "R3 write cycle length", n, WCYC);
    send(3'b001, 1'b0, 5'd3, 8'h00); expect_rsp(8'h3C, "R3 read back");
    send(3'b001, 1'b1, 5'd0, 8'h5A); wait_idle(n);
    send(3'b001, 1'b0, 5'd0, 8'h00); expect_rsp(8'h5A, "R3 read home");

    // R4 store
    send(3'b000, 1'b1, 5'd0, 8'hA5);
    send(3'b110, 1'b0, 5'd0, 8'h00);
    wait_idle(n);
    chk(n == WCYC, "R4 store cycle length", n, WCYC);
    send(3'b001, 1'b0, 5'd0, 8'h00); expect_rsp(8'hA5, "R4 stored wiper");

    // R5 restore
    send(3'b000, 1'b1, 5'd0, 8'h11);
    send(3'b101, 1'b0, 5'd0, 8'h00);
    chk(!busy, "R5 restore no busy", busy, 0);
    chk(wiper == 8'hA5, "R5 restore value", wiper, 8'hA5);

    // R7 tolerance bytes, write refused
    send(3'b001, 1'b0, 5'd30, 8'h00); expect_rsp(TOL_HI, "R7 sign+integer byte");
    send(3'b001, 1'b0, 5'd31, 8'h00); expect_rsp(TOL_LO, "R7 fraction byte");
    send(3'b001, 1'b1, 5'd30, 8'h00);
    chk(err && !busy, "R7 rom write refused", {err, busy}, 2'b10);
    @(negedge clk);
    chk(!err, "R10 err one cycle", err, 0);
    send(3'b001, 1'b0, 5'd30, 8'h00); expect_rsp(TOL_HI, "R7 rom unchanged");

    // R6 write protect
    send(3'b010, 1'b1, 5'd0, 8'h01);
    chk(wp_on, "R6 lock set", wp_on, 1);
    send(3'b010, 1'b0, 5'd0, 8'h00); expect_rsp(8'h01, "R6 lock read");
    send(3'b001, 1'b1, 5'd3, 8'h77);
    chk(err && !busy, "R6 locked write refused", {err, busy}, 2'b10);
    send(3'b001, 1'b0, 5'd3, 8'h00); expect_rsp(8'h3C, "R6 byte unchanged");
    send(3'b000, 1'b1, 5'd0, 8'h42);
    send(3'b110, 1'b0, 5'd0, 8'h00);
    chk(err && !busy, "R6 locked store refused", {err, busy}, 2'b10);
    send(3'b001, 1'b0, 5'd0, 8'h00); expect_rsp(8'hA5, "R6 home unchanged");
    send(3'b010, 1'b1, 5'd0, 8'h02);
    chk(!wp_on, "R6 lock cleared by bit0=0", wp_on, 0);
    send(3'b001, 1'b1, 5'd3, 8'h77); wait_idle(n);
    chk(n == WCYC, "R6 write after unlock", n, WCYC);
    send(3'b001, 1'b0, 5'd3, 8'h00); expect_rsp(8'h77, "R6 unlocked byte");

    // R9 unknown and no-op commands
    send(3'b011, 1'b1, 5'd0, 8'h99);
    chk(err && wiper == 8'h42, "R9 unknown 011", {err, wiper}, {1'b1, 8'h42});
    send(3'b111, 1'b1, 5'd0, 8'h99);
    chk(err && wiper == 8'h42, "R9 unknown 111", {err, wiper}, {1'b1, 8'h42});
    send(3'b100, 1'b1, 5'd0, 8'h99);
    chk(!err && !busy && wiper == 8'h42, "R9 nop quiet", {err, busy, wiper}, {2'b00, 8'h42});

    // R8 response back-pressure
    rsp_ready = 1'b0;
    send(3'b000, 1'b0, 5'd0, 8'h00); expect_rsp(8'h42, "R8 stalled read");
    held = rsp_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_data == held, "R8 response held",
          rsp_data, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);

    // R1 stored home byte survives reset and is refreshed
    send(3'b000, 1'b1, 5'd0, 8'h22);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(wiper == 8'h00 && busy, "R1 reset clears wiper", wiper, 0);
    rst_n = 1'b1;
    wait_idle(n);
    chk(n > 0 && n <= RCYC, "R1 refresh bound", n, RCYC);
    chk(wiper == 8'hA5, "R1 refresh value", wiper, 8'hA5);

    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule